// File: doc/BRIEF.md
# Opcode Redirection Handle Table

This block lets a small, fixed group of generic instruction slots be re-targeted at run time to different extension behaviours. Each of the eight slots holds an extension identifier. An open command binds an identifier to a slot. A close command returns the slot to the reserved empty value, which is all ones. When the core issues a generic opcode, it presents the slot number as a dispatch request. The block then answers in the same cycle: either a one-hot select naming which known extension runs that slot's function, or an illegal-instruction flag that makes the core trap.

Identifiers are 16-bit indices into a list of registered extensions. Two extensions are built in, with identifiers 1 and 2. An identifier that is not recognised traps exactly like an empty slot. Instruction decoding, the extension functions themselves and privilege checks all live outside the block.

Top module: `redir_handle_table`

## Requirements
- R1: After reset every slot holds the empty value (all ones), so a dispatch to any of the eight slots raises `disp_illegal` with `disp_sel` zero.
- R2: An open command stores `open_id` in slot `open_slot` at the clock edge. A later dispatch to that slot selects `disp_sel` = 2'b01 for identifier 1 and 2'b10 for identifier 2, with `disp_illegal` low.
- R3: A close command stores all ones in slot `close_slot` at the clock edge. Later dispatches to that slot raise `disp_illegal`.
- R4: A slot holding any value other than a known identifier raises `disp_illegal` on dispatch, with `disp_sel` zero. Examples are 0, 3 and 16'h1234.
- R5: A dispatch in the same cycle as a write to the same slot reports the value held before that write.
- R6: When open and close name the same slot in one cycle, the slot becomes empty.
- R7: When open and close name different slots in one cycle, both writes take effect.
- R8: A write changes only the slot it names. The bindings of all other slots are unchanged.
- R9: `disp_rsp_vld` follows `disp_vld`. While it is low, `disp_sel`, `disp_illegal` and `disp_fn` are all zero.
- R10: For a valid dispatch, exactly one of the following is true: one bit of `disp_sel` is set, or `disp_illegal` is high.
- R11: For a dispatch that selects an extension, `disp_fn` equals the dispatched slot number, which is the function index within that extension. On an illegal dispatch, `disp_fn` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| open_vld | input | 1 | Open command strobe |
| open_slot | input | 3 | Slot to bind |
| open_id | input | 16 | Extension identifier to store |
| close_vld | input | 1 | Close command strobe |
| close_slot | input | 3 | Slot to clear |
| disp_vld | input | 1 | Dispatch request strobe |
| disp_slot | input | 3 | Slot of the generic opcode being dispatched |
| disp_rsp_vld | output | 1 | Dispatch response valid |
| disp_sel | output | 2 | One-hot select of the known extension |
| disp_illegal | output | 1 | Undefined-opcode trap request |
| disp_fn | output | 3 | Function index passed to the selected extension |

## Verification
The bench builds the block with its default parameters: eight slots, 16-bit identifiers and two known extensions starting at identifier 1. With these values every slot can be visited, and both known identifiers can be set against identifier 0, identifier 3 (one past the last known identifier), an arbitrary identifier and the all-ones empty value. The same-cycle cases are covered with directed stimulus: open/close collisions on one slot, open and close on different slots, and a dispatch made during a write.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam int DEF_SLOTS    = 8;
  localparam int DEF_ID_W     = 16;
  localparam int DEF_EXT_CNT  = 2;
  localparam int DEF_EXT_BASE = 1;

  // Identifier assigned to known extension k.
  function automatic int ext_ident(input int base, input int k);
    return base + k;
  endfunction
endpackage

// File: rtl/redir_slot_store.sv
module redir_slot_store #(
  parameter int NUM_SLOTS = 8,
  parameter int ID_W      = 16,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_open,
  input  logic [SLOT_W-1:0] wr_open_slot,
  input  logic [ID_W-1:0]   wr_open_id,
  input  logic              wr_close,
  input  logic [SLOT_W-1:0] wr_close_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ID_W-1:0]   rd_id
);
  localparam logic [ID_W-1:0] EMPTY = '1;

  logic [ID_W-1:0] tbl [NUM_SLOTS];

  // Open is suppressed when close targets the same slot: close wins.
  logic open_eff;
  assign open_eff = wr_open && !(wr_close && (wr_close_slot == wr_open_slot));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) tbl[i] <= EMPTY;
    end else begin
      if (open_eff) tbl[wr_open_slot] <= wr_open_id;
      if (wr_close) tbl[wr_close_slot] <= EMPTY;
    end
  end

  // Asynchronous read: dispatch sees the value before any same-cycle write.
  assign rd_id = tbl[rd_slot];

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (tbl[0] == EMPTY) && (tbl[NUM_SLOTS-1] == EMPTY));

  p_close_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_open && wr_close && (wr_open_slot == wr_close_slot))
      |=> (tbl[$past(wr_close_slot)] == EMPTY));

  p_close_clears_r3: assert property (@(posedge clk) disable iff (rst)
    wr_close |=> (tbl[$past(wr_close_slot)] == EMPTY));

  p_open_stores_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_open && !(wr_close && (wr_close_slot == wr_open_slot)))
      |=> (tbl[$past(wr_open_slot)] == $past(wr_open_id)));
endmodule

// File: rtl/redir_id_match.sv
module redir_id_match #(
  parameter int ID_W     = 16,
  parameter int EXT_CNT  = 2,
  parameter int EXT_BASE = 1
) (
  input  logic [ID_W-1:0]    id_i,
  output logic [EXT_CNT-1:0] hit_o
);
  for (genvar k = 0; k < EXT_CNT; k++) begin : g_ext
    localparam logic [ID_W-1:0] KNOWN = ID_W'(redir_pkg::ext_ident(EXT_BASE, k));
    assign hit_o[k] = (id_i == KNOWN);
  end

  always_comb begin
    assert ($onehot0(hit_o)) else $error("p_hit_unique_r10: multiple matches");
  end
endmodule

// File: rtl/redir_handle_table.sv
module redir_handle_table #(
  parameter int NUM_SLOTS = redir_pkg::DEF_SLOTS,
  parameter int ID_W      = redir_pkg::DEF_ID_W,
  parameter int EXT_CNT   = redir_pkg::DEF_EXT_CNT,
  parameter int EXT_BASE  = redir_pkg::DEF_EXT_BASE,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               open_vld,
  input  logic [SLOT_W-1:0]  open_slot,
  input  logic [ID_W-1:0]    open_id,
  input  logic               close_vld,
  input  logic [SLOT_W-1:0]  close_slot,
  input  logic               disp_vld,
  input  logic [SLOT_W-1:0]  disp_slot,
  output logic               disp_rsp_vld,
  output logic [EXT_CNT-1:0] disp_sel,
  output logic               disp_illegal,
  output logic [SLOT_W-1:0]  disp_fn
);
  logic [ID_W-1:0]    slot_id;
  logic [EXT_CNT-1:0] hit;
  logic               any_hit;

  redir_slot_store #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) store_i (
    .clk          (clk),
    .rst          (rst),
    .wr_open      (open_vld),
    .wr_open_slot (open_slot),
    .wr_open_id   (open_id),
    .wr_close     (close_vld),
    .wr_close_slot(close_slot),
    .rd_slot      (disp_slot),
    .rd_id        (slot_id)
  );

  redir_id_match #(.ID_W(ID_W), .EXT_CNT(EXT_CNT), .EXT_BASE(EXT_BASE)) match_i (
    .id_i (slot_id),
    .hit_o(hit)
  );

  assign any_hit      = |hit;
  assign disp_rsp_vld = disp_vld;
  assign disp_sel     = disp_vld ? hit : '0;
  assign disp_illegal = disp_vld && !any_hit;
  assign disp_fn      = (disp_vld && any_hit) ? disp_slot : '0;

  p_one_outcome_r10: assert property (@(posedge clk) disable iff (rst)
    disp_rsp_vld |-> (($countones(disp_sel) + 32'(disp_illegal)) == 1));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !disp_vld |-> (disp_sel == '0) && !disp_illegal && (disp_fn == '0));

  p_fn_index_r11: assert property (@(posedge clk) disable iff (rst)
    (disp_sel != '0) |-> (disp_fn == disp_slot));
endmodule

// File: tb/redir_handle_table_tb_top.sv
module redir_handle_table_tb_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] EMPTY = 16'hFFFF;

  logic clk = 1'b0;
  logic rst;
  logic open_vld, close_vld, disp_vld;
  logic [2:0] open_slot, close_slot, disp_slot;
  logic [15:0] open_id;
  logic disp_rsp_vld, disp_illegal;
  logic [1:0] disp_sel;
  logic [2:0] disp_fn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  redir_handle_table dut_i (
    .clk(clk), .rst(rst),
    .open_vld(open_vld), .open_slot(open_slot), .open_id(open_id),
    .close_vld(close_vld), .close_slot(close_slot),
    .disp_vld(disp_vld), .disp_slot(disp_slot),
    .disp_rsp_vld(disp_rsp_vld), .disp_sel(disp_sel),
    .disp_illegal(disp_illegal), .disp_fn(disp_fn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    open_vld = 0; close_vld = 0; disp_vld = 0;
    open_slot = 0; close_slot = 0; disp_slot = 0; open_id = 0;
  endtask

  // Wait for the edge, then move away from it before driving or sampling.
  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_open(input logic [2:0] s, input logic [15:0] id);
    open_vld = 1; open_slot = s; open_id = id; step();
  endtask

  task automatic do_close(input logic [2:0] s);
    close_vld = 1; close_slot = s; step();
  endtask

  // Combinational lookup, sampled mid-cycle.
  task automatic expect_disp(input string req, input logic [2:0] s, input logic [15:0] id);
    logic [1:0] es;
    es = (id == 16'd1) ? 2'b01 : (id == 16'd2) ? 2'b10 : 2'b00;
    disp_vld = 1; disp_slot = s; #1;
    chk({req, " vld"}, 32'(disp_rsp_vld), 1);
    chk({req, " sel"}, 32'(disp_sel), 32'(es));
    chk({req, " illegal"}, 32'(disp_illegal), 32'(es == 0));
    chk({req, " fn"}, 32'(disp_fn), (es != 0) ? 32'(s) : 0);
    disp_vld = 0; disp_slot = 0; #1;
  endtask

  task automatic t_reset();
    for (int s = 0; s < 8; s++) expect_disp("R1 reset empty", 3'(s), EMPTY);
  endtask

  task automatic t_open_close();
    do_open(3, 16'd1);  expect_disp("R2 id1", 3, 16'd1);
    do_open(5, 16'd2);  expect_disp("R2 id2", 5, 16'd2);
    do_open(0, 16'd2);  expect_disp("R2 slot0", 0, 16'd2);
    do_open(7, 16'd1);  expect_disp("R2 slot7", 7, 16'd1);
    do_close(3);        expect_disp("R3 closed", 3, EMPTY);
    do_open(3, 16'd2);  expect_disp("R2 rebind", 3, 16'd2);
  endtask

  task automatic t_unknown();
    do_open(1, 16'd0);     expect_disp("R4 id0", 1, 16'd0);
    do_open(1, 16'd3);     expect_disp("R4 id3", 1, 16'd3);
    do_open(1, 16'h1234);  expect_disp("R4 id1234", 1, 16'h1234);
    do_open(1, EMPTY);     expect_disp("R4 explicit empty", 1, EMPTY);
  endtask

  task automatic t_same_cycle_read();
    // slot 5 holds 2; open it with 1 while dispatching slot 5
    open_vld = 1; open_slot = 5; open_id = 16'd1;
    expect_disp("R5 old before open", 5, 16'd2);
    step();
    expect_disp("R5 new after open", 5, 16'd1);
    close_vld = 1; close_slot = 5;
    expect_disp("R5 old before close", 5, 16'd1);
    step();
    expect_disp("R5 after close", 5, EMPTY);
  endtask

  task automatic t_collide();
    do_open(2, 16'd1);
    open_vld = 1; open_slot = 2; open_id = 16'd2; close_vld = 1; close_slot = 2; step();
    expect_disp("R6 close wins", 2, EMPTY);
    do_open(4, 16'd1);
    open_vld = 1; open_slot = 6; open_id = 16'd2; close_vld = 1; close_slot = 4; step();
    expect_disp("R7 open other", 6, 16'd2);
    expect_disp("R7 close other", 4, EMPTY);
  endtask

  task automatic t_isolation();
    // Known state: 0->2, 1->EMPTY, 2->EMPTY, 3->2, 4->EMPTY, 5->EMPTY, 6->2, 7->1
    do_open(1, 16'd1);
    expect_disp("R8 slot0 kept", 0, 16'd2);
    expect_disp("R8 slot2 kept", 2, EMPTY);
    expect_disp("R8 slot3 kept", 3, 16'd2);
    expect_disp("R8 slot7 kept", 7, 16'd1);
    do_close(0);
    expect_disp("R8 slot1 kept", 1, 16'd1);
    expect_disp("R8 slot6 kept", 6, 16'd2);
  endtask

  task automatic t_idle();
    disp_vld = 0; disp_slot = 7; #1;   // slot 7 is bound, yet no request
    chk("R9 vld low", 32'(disp_rsp_vld), 0);
    chk("R9 sel zero", 32'(disp_sel), 0);
    chk("R9 illegal low", 32'(disp_illegal), 0);
    chk("R9 fn zero", 32'(disp_fn), 0);
    disp_slot = 0;
    expect_disp("R10 R11 bound", 7, 16'd1);
    expect_disp("R10 R11 trap", 0, EMPTY);
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_open_close();
    t_unknown();
    t_same_cycle_read();
    t_collide();
    t_isolation();
    t_idle();
    // Reset again and confirm the table empties
    rst = 1; step(); rst = 0;
    expect_disp("R1 re-reset", 7, EMPTY);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule